// File: doc/BRIEF.md
# Serial NOR Flash Write-Protect Unit

This block holds the write-enable latch and the status byte of a serial NOR flash device model. It also decides, for every program or erase request, whether the request may go ahead. A byte-level command decoder ahead of it passes in one-cycle opcode strobes, with the data byte that goes with a status write. The decoder also passes the level of the active-low hardware write-protect pin. Every program, sector erase or bulk erase request reaches the block with its target byte address. One cycle after each request the block returns a verdict, and the memory array acts only on a positive verdict.

Protection is set by a 4-bit level held in the status byte. Level zero protects nothing. A nonzero level n covers 2^(n-1) sectors of 64 KiB, up to the whole device. A top/bottom bit chooses whether the covered sectors sit at the high end or start at sector 0. The status byte can be frozen: when the hardware write-protect pin is held low and the status-lock bit is set, status writes have no effect.

Top module: `nor_wp_unit`

## Requirements
- R1: After reset, status_byte is 0x00, the write-enable latch is clear, and resp_valid and rd_valid are low.
- R2: Command 0x06 sets the write-enable latch and command 0x04 clears it. The latch reads as bit 1 of status_byte from the cycle after the command.
- R3: Command 0x01 with a data byte is a status write. It succeeds only while the latch is set and (wp_n is high or the lock bit, status bit 7, is 0). A successful write loads status bits 7..2 from the data byte and clears the latch. Bit 0 always reads 0.
- R4: When wp_n is low and status bit 7 is 1, a status write changes no status bit, the lock bit included, and leaves the latch set.
- R5: Command 0x05 raises rd_valid for one cycle. In that cycle rd_byte holds status_byte as it stood before the edge that captured the command.
- R6: The protect level is {status bit 6, bits 4..2}, with bit 6 as the most significant. Level 0 protects no sector. A level n > 0 protects min(2^(n-1), 512) sectors.
- R7: The sector number is req_addr[24:16]. With the top/bottom bit (status bit 5) at 0, the protected sectors are the highest-numbered ones. With it at 1, they run upward from sector 0.
- R8: req_kind codes are 0 or 3 for program, 1 for sector erase and 2 for bulk erase. Each request gives resp_valid on the next cycle. resp_ok is 1 only if the latch was set and the target sector is unprotected.
- R9: A bulk erase is refused whenever the protect level is nonzero.
- R10: An accepted request clears the latch. A refused request leaves the latch unchanged.
- R11: A request and a command in the same cycle: the request is judged on the latch as it was before that cycle. A 0x06 or 0x04 in that cycle sets the final latch value. A status write in that cycle takes effect only if the request was not accepted.
- R12: A status write while the latch is clear changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Opcode strobe from the command decoder |
| cmd_op | input | 8 | Decoded opcode |
| cmd_data | input | 8 | Data byte of a status write |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| req_valid | input | 1 | Program or erase request strobe |
| req_kind | input | 2 | Request kind: 0/3 program, 1 sector erase, 2 bulk erase |
| req_addr | input | 25 | Target byte address |
| resp_valid | output | 1 | Verdict valid, one cycle after the request |
| resp_ok | output | 1 | Request allowed |
| rd_valid | output | 1 | Status read data valid |
| rd_byte | output | 8 | Status byte returned by a status read |
| status_byte | output | 8 | Live status: lock, level MSB, top/bottom, level[2:0], latch, 0 |

## Verification
A request and a command can fall in the same cycle, and then both compete for the write-enable latch. An accepted program must use up the latch, and a status write, 0x06 or 0x04 arriving in that cycle must still end in the right state. The bench provokes this on purpose: it pairs an allowed program with each of those three commands. A long random phase then drives both strobes at once with high probability. A behavioural model applies the ordering rule, request first and command second, and every cycle the bench compares the latch, the status byte and the verdict against it.

// File: rtl/nor_wp_pkg.sv
package nor_wp_pkg;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_RDSR = 8'h05;

  localparam logic [1:0] KIND_BULK = 2'd2;

  localparam int LEVEL_W = 4;

  // Field order mirrors status bits 7..2, which the command decoder relies on.
  typedef struct packed {
    logic       lock;
    logic       lvl_hi;
    logic       from_bottom;
    logic [2:0] lvl_lo;
  } prot_cfg_t;

endpackage

// File: rtl/nor_wp_wel.sv
module nor_wp_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic consume_i,
  output logic wel_o
);

  logic wel_d;

  always_comb begin
    wel_d = wel_o;
    if (set_i)          wel_d = 1'b1;
    else if (clr_i)     wel_d = 1'b0;
    else if (consume_i) wel_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wel_o <= 1'b0;
    else        wel_o <= wel_d;
  end

endmodule

// File: rtl/nor_wp_cfg.sv
module nor_wp_cfg
  import nor_wp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_i,
  input  prot_cfg_t data_i,
  output prot_cfg_t cfg_o
);

  prot_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_o;
    if (load_i) cfg_d = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_o <= '0;
    else        cfg_o <= cfg_d;
  end

endmodule

// File: rtl/nor_wp_region.sv
module nor_wp_region
  import nor_wp_pkg::*;
#(
  parameter int SECTOR_W       = 9,
  parameter int SECTOR_BYTES_W = 16,
  localparam int ADDR_W        = SECTOR_W + SECTOR_BYTES_W,
  localparam int CNT_W         = SECTOR_W + 1
) (
  input  logic [LEVEL_W-1:0] level_i,
  input  logic               from_bottom_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               hit_o,
  output logic               any_o
);

  localparam logic [CNT_W-1:0] NUM_SECT = CNT_W'(1) << SECTOR_W;
  localparam int               LVL_FULL = SECTOR_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [ADDR_W:0]  bot_end;
  logic [ADDR_W:0]  top_start;
  logic [ADDR_W:0]  addr_x;

  generate
    if (LVL_FULL >= (1 << LEVEL_W) - 1) begin : g_nocap
      always_comb begin
        if (level_i == '0) cnt = '0;
        else               cnt = CNT_W'(1) << (level_i - 1'b1);
      end
    end else begin : g_cap
      always_comb begin
        if (level_i == '0)                 cnt = '0;
        else if (int'(level_i) > LVL_FULL) cnt = NUM_SECT;
        else                               cnt = CNT_W'(1) << (level_i - 1'b1);
      end
    end
  endgenerate

  always_comb begin
    addr_x    = {1'b0, addr_i};
    bot_end   = {cnt, {SECTOR_BYTES_W{1'b0}}};
    top_start = {NUM_SECT - cnt, {SECTOR_BYTES_W{1'b0}}};
    if (from_bottom_i) hit_o = addr_x < bot_end;
    else               hit_o = (cnt != '0) && (addr_x >= top_start);
    any_o = cnt != '0;
  end

endmodule

// File: rtl/nor_wp_unit.sv
module nor_wp_unit
  import nor_wp_pkg::*;
#(
  parameter int SECTOR_W       = 9,
  parameter int SECTOR_BYTES_W = 16,
  localparam int ADDR_W        = SECTOR_W + SECTOR_BYTES_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [7:0]        cmd_data,
  input  logic              wp_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  output logic              resp_ok,
  output logic              rd_valid,
  output logic [7:0]        rd_byte,
  output logic [7:0]        status_byte
);

  logic      is_wren, is_wrdi, is_wrsr, is_rdsr;
  logic      wel_q;
  prot_cfg_t cfg_q;
  prot_cfg_t cfg_new;
  logic [1:0] unused_low;
  logic [LEVEL_W-1:0] level;
  logic      sect_hit, any_prot;
  logic      req_ok, wrsr_ok;
  logic      resp_valid_d, resp_ok_d, rd_valid_d;
  logic [7:0] rd_byte_d;

  assign is_wren = cmd_valid && (cmd_op == OP_WREN);
  assign is_wrdi = cmd_valid && (cmd_op == OP_WRDI);
  assign is_wrsr = cmd_valid && (cmd_op == OP_WRSR);
  assign is_rdsr = cmd_valid && (cmd_op == OP_RDSR);

  assign cfg_new    = prot_cfg_t'(cmd_data[7:2]);
  assign unused_low = cmd_data[1:0];
  assign level      = {cfg_q.lvl_hi, cfg_q.lvl_lo};

  nor_wp_region #(
    .SECTOR_W      (SECTOR_W),
    .SECTOR_BYTES_W(SECTOR_BYTES_W)
  ) i_region (
    .level_i      (level),
    .from_bottom_i(cfg_q.from_bottom),
    .addr_i       (req_addr),
    .hit_o        (sect_hit),
    .any_o        (any_prot)
  );

  always_comb begin
    req_ok = req_valid && wel_q &&
             ((req_kind == KIND_BULK) ? !any_prot : !sect_hit);
    wrsr_ok = is_wrsr && wel_q && !req_ok && (wp_n || !cfg_q.lock);
  end

  nor_wp_wel i_wel (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (is_wren),
    .clr_i    (is_wrdi),
    .consume_i(req_ok || wrsr_ok),
    .wel_o    (wel_q)
  );

  nor_wp_cfg i_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(wrsr_ok),
    .data_i(cfg_new),
    .cfg_o (cfg_q)
  );

  assign status_byte = {cfg_q, wel_q, 1'b0};

  always_comb begin
    resp_valid_d = req_valid;
    resp_ok_d    = req_ok;
    rd_valid_d   = is_rdsr;
    rd_byte_d    = rd_byte;
    if (is_rdsr) rd_byte_d = status_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_ok    <= 1'b0;
      rd_valid   <= 1'b0;
      rd_byte    <= '0;
    end else begin
      resp_valid <= resp_valid_d;
      resp_ok    <= resp_ok_d;
      rd_valid   <= rd_valid_d;
      rd_byte    <= rd_byte_d;
    end
  end

endmodule

// File: rtl/nor_wp_unit_chk.sv
module nor_wp_unit_chk
  import nor_wp_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [7:0] cmd_op,
  input logic       wp_n,
  input logic       req_valid,
  input logic [1:0] req_kind,
  input logic       resp_valid,
  input logic       resp_ok,
  input logic       rd_valid,
  input logic [7:0] rd_byte,
  input logic [7:0] status_byte
);

  p_wren_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_WREN) |=> status_byte[1]);

  p_wrdi_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_WRDI) |=> !status_byte[1]);

  p_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_WRSR && !wp_n && status_byte[7])
    |=> $stable(status_byte[7:2]));

  p_no_latch_no_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !status_byte[1]) |=> (resp_valid && !resp_ok));

  p_bulk_refused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == KIND_BULK &&
     (status_byte[6] || status_byte[4:2] != 3'd0)) |=> !resp_ok);

  p_grant_consumes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !cmd_valid) |=> !(resp_ok && status_byte[1]));

  p_read_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_RDSR) |=> (rd_valid && rd_byte == $past(status_byte)));

  p_no_stray_verdict_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);

endmodule

bind nor_wp_unit nor_wp_unit_chk i_chk (.*);

// File: tb/test_nor_wp_unit.sv
module test_nor_wp_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_op = '0;
  logic [7:0]  cmd_data = '0;
  logic        wp_n = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [24:0] req_addr = '0;
  logic        resp_valid, resp_ok, rd_valid;
  logic [7:0]  rd_byte, status_byte;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nor_wp_unit i_nor_wp_unit (.*);

  // reference model
  int m_wel, m_lock, m_lvl, m_bot, m_rv, m_rok, m_rdv, m_rdb;

  function automatic int m_status();
    return (m_lock << 7) | ((m_lvl >> 3) << 6) | (m_bot << 5) |
           ((m_lvl & 7) << 2) | (m_wel << 1);
  endfunction

  function automatic int prot_cnt(int lvl);
    if (lvl == 0) return 0;
    if (lvl - 1 >= 9) return 512;
    return 1 << (lvl - 1);
  endfunction

  function automatic bit is_prot(int lvl, int bot, int sec);
    int c = prot_cnt(lvl);
    if (bot != 0) return sec < c;
    return sec >= 512 - c;
  endfunction

  always @(posedge clk) begin
    int sb, sec;
    bit ok;
    if (!rst_n) begin
      m_wel = 0; m_lock = 0; m_lvl = 0; m_bot = 0;
      m_rv = 0; m_rok = 0; m_rdv = 0; m_rdb = 0;
    end else begin
      sb  = m_status();
      sec = int'(req_addr >> 16);
      ok  = req_valid && (m_wel != 0) &&
            ((req_kind == 2'd2) ? (m_lvl == 0) : !is_prot(m_lvl, m_bot, sec));
      m_rv  = int'(req_valid);
      m_rok = int'(ok);
      if (ok) m_wel = 0;
      m_rdv = 0;
      if (cmd_valid) begin
        case (cmd_op)
          8'h06: m_wel = 1;
          8'h04: m_wel = 0;
          8'h01: if (m_wel != 0 && (wp_n || m_lock == 0)) begin
            m_lock = int'(cmd_data[7]);
            m_lvl  = (int'(cmd_data[6]) << 3) | int'(cmd_data[4:2]);
            m_bot  = int'(cmd_data[5]);
            m_wel  = 0;
          end
          8'h05: begin m_rdv = 1; m_rdb = sb; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("model status R2 R3", int'(status_byte), m_status());
      chk("model resp_valid R8", int'(resp_valid), m_rv);
      chk("model resp_ok R8 R11", int'(resp_ok), m_rok);
      chk("model rd_valid R5", int'(rd_valid), m_rdv);
      chk("model rd_byte R5", int'(rd_byte), m_rdb);
    end
  end

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    req_valid = 1'b0;
  endtask

  task automatic cmd(logic [7:0] op, logic [7:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    cyc();
  endtask

  task automatic set_sr(logic [7:0] d);
    cmd(8'h06, 8'h00);
    cmd(8'h01, d);
  endtask

  task automatic request(int kind, int sec);
    req_valid = 1'b1; req_kind = 2'(kind);
    req_addr = 25'((sec << 16) | 16'h3a5c);
    cyc();
  endtask

  function automatic logic [7:0] sr_for(int lvl, int bot);
    return 8'(((lvl & 8) << 3) | (bot << 5) | ((lvl & 7) << 2));
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status at reset", int'(status_byte), 0);
    chk("R1 resp_valid at reset", int'(resp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status after release", int'(status_byte), 0);
    chk("R1 rd_valid after release", int'(rd_valid), 0);

    cmd(8'h06, 8'h00);
    chk("R2 latch set", int'(status_byte[1]), 1);
    cmd(8'h04, 8'h00);
    chk("R2 latch cleared", int'(status_byte[1]), 0);

    cmd(8'h01, 8'hfc);
    chk("R12 write without latch", int'(status_byte), 0);
    request(0, 5);
    chk("R8 program without latch", int'(resp_ok), 0);
    chk("R8 verdict valid", int'(resp_valid), 1);

    set_sr(8'h83);
    chk("R3 lock written, low bits dropped", int'(status_byte), 8'h80);
    wp_n = 1'b0;
    set_sr(8'h00);
    chk("R4 locked write ignored, latch kept", int'(status_byte), 8'h82);
    cmd(8'h04, 8'h00);
    set_sr(8'h00);
    chk("R4 still locked", int'(status_byte[7]), 1);
    wp_n = 1'b1;
    cmd(8'h01, 8'h00);
    chk("R3 unlocked by wp_n high", int'(status_byte), 0);
    wp_n = 1'b0;
    set_sr(8'h5c);
    chk("R3 wp_n low, lock clear: write ok", int'(status_byte), 8'h5c);
    wp_n = 1'b1;

    cmd(8'h05, 8'h00);
    chk("R5 rd_valid", int'(rd_valid), 1);
    chk("R5 rd_byte", int'(rd_byte), 8'h5c);
    @(negedge clk);
    chk("R5 rd_valid one cycle", int'(rd_valid), 0);

    for (int lvl = 0; lvl < 16; lvl++) begin
      for (int bot = 0; bot < 2; bot++) begin
        int c = prot_cnt(lvl);
        int secs[8] = '{0, 1, c - 1, c, 511 - c, 512 - c, 510, 511};
        set_sr(sr_for(lvl, bot));
        chk("R6 level encoding", int'(status_byte), int'(sr_for(lvl, bot)));
        cmd(8'h06, 8'h00);
        request(2, 0);
        chk("R9 bulk verdict", int'(resp_ok), int'(lvl == 0));
        chk("R10 latch after bulk", int'(status_byte[1]), int'(lvl != 0));
        foreach (secs[k]) begin
          int s = secs[k];
          if (s < 0) s = 0;
          if (s > 511) s = 511;
          cmd(8'h06, 8'h00);
          request(k & 1, s);
          chk(bot ? "R7 bottom region" : "R6 R7 top region",
              int'(resp_ok), int'(!is_prot(lvl, bot, s)));
        end
      end
    end

    set_sr(8'h00);
    cmd(8'h06, 8'h00);
    req_valid = 1'b1; req_kind = 2'd0; req_addr = 25'h10000;
    cmd_valid = 1'b1; cmd_op = 8'h06;
    cyc();
    chk("R11 grant with wren", int'(resp_ok), 1);
    chk("R11 wren wins latch", int'(status_byte[1]), 1);
    req_valid = 1'b1; cmd_valid = 1'b1; cmd_op = 8'h01; cmd_data = 8'h9c;
    cyc();
    chk("R11 grant beats status write", int'(resp_ok), 1);
    chk("R11 status write dropped", int'(status_byte), 0);
    cmd(8'h06, 8'h00);
    req_valid = 1'b1; cmd_valid = 1'b1; cmd_op = 8'h04;
    cyc();
    chk("R11 grant with wrdi", int'(resp_ok), 1);
    chk("R11 latch clear", int'(status_byte[1]), 0);

    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(0, 7));
      logic [7:0] ops[6] = '{8'h06, 8'h04, 8'h01, 8'h05, 8'h06, 8'hc7};
      cmd_valid = ($urandom_range(0, 3) != 0);
      cmd_op    = ops[r % 6];
      cmd_data  = 8'($urandom);
      wp_n      = ($urandom_range(0, 2) != 0);
      req_valid = ($urandom_range(0, 1) != 0);
      req_kind  = 2'($urandom);
      req_addr  = 25'($urandom);
      cyc();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule